// File: doc/BRIEF.md
# Maskable Interrupt Control Unit

This block gates and ranks the maskable interrupt requests of a small 8-bit processor core. It watches four request lines: an external request that brings its own vector, two level-sensitive restart lines (numbered 5 and 6), and an edge-triggered restart line (numbered 7). A request reaches the core only when a global enable flip-flop is set and the line's own software mask is clear. The highest-ranked live request drives `req_o` and a 16-bit vector.

The core controls the unit with single-cycle strobes. One strobe sets the global enable and another clears it. A mask-write strobe carries an 8-bit accumulator word. That word can reload the three restart masks, clear the latched line-7 request, and update a serial output bit. A status-read strobe captures an 8-bit status word, which includes the serial input pin. An acknowledge strobe tells the unit that the presented request was taken. On that acknowledge the unit drops the global enable and, for line 7, clears its latch.

The status word leaves the block as a one-beat transfer: `status_vld_o` pulses for one cycle, and `status_o` holds its value until the next read. The core always takes the beat, so there is no ready signal and no back-pressure. The request lines and strobes are plain control pins and are assumed to be synchronous to `clk`.

Top module: `intmask_ctrl`

## Requirements
- R1: After reset the following hold: global enable 0, all three masks 1 (masked), line-7 latch 0, serial output 0, `req_o` 0 and `status_vld_o` 0.
- R2: `en_stb_i` sets the global enable on the next edge and `dis_stb_i` clears it. When both are active in the same cycle, or enable coincides with an accepted acknowledge, the enable ends up clear.
- R3: An acknowledge while `req_o` is 1 clears the global enable on the next edge. An acknowledge while `req_o` is 0 has no effect.
- R4: A mask write with word bit 3 = 1 loads the masks from bits 2..0 (bit 0 = line 5, bit 1 = line 6, bit 2 = line 7; 1 = masked). With bit 3 = 0 the masks are unchanged. Writing 08h unmasks all three lines.
- R5: The line-7 latch is set by a rising edge on `irq_l7_i`, meaning the pin is 0 at one clock edge and 1 at the next. The mask and the global enable do not affect this. The latch stays set after the pin falls. A pin that is held high does not set it again, and a pin that is high across reset does not set it.
- R6: The line-7 latch is cleared by a mask write with bit 4 = 1, or by an acknowledge while line 7 is the presented source. A rising edge in the same cycle as a clear wins. An acknowledge of any other line leaves the latch unchanged.
- R7: On a mask write with bit 6 = 1, `ser_out_o` takes bit 7 of the word. With bit 6 = 0 it holds. Bit 5 has no effect.
- R8: A read strobe makes `status_vld_o` 1 for the next cycle and loads `status_o` with this layout: bits 2..0 masks, bit 3 global enable, bit 4 line-5 pin, bit 5 line-6 pin, bit 6 line-7 latch, bit 7 `ser_in_i`.
- R9: `req_o` is 1 in the same cycle if and only if the global enable is set and at least one line is requesting and not masked. The external line has no mask.
- R10: Priority runs line 7 > line 6 > line 5 > external. The vectors are 003Ch, 0034h and 002Ch. When the external line wins, `vec_ext_o` is 1 and `vec_o` is 0.
- R11: Lines 5 and 6 are level-sensitive. Dropping the pin removes the request in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_ext_i | input | 1 | External request line (vector supplied externally) |
| irq_l5_i | input | 1 | Restart line 5, level |
| irq_l6_i | input | 1 | Restart line 6, level |
| irq_l7_i | input | 1 | Restart line 7, rising edge |
| en_stb_i | input | 1 | Set global enable |
| dis_stb_i | input | 1 | Clear global enable |
| mw_stb_i | input | 1 | Mask-write strobe |
| mw_data_i | input | 8 | Accumulator word for the mask write |
| rd_stb_i | input | 1 | Status-read strobe |
| ack_i | input | 1 | Core accepted the presented request |
| ser_in_i | input | 1 | Serial input bit, sampled on read |
| req_o | output | 1 | Prioritized request to core |
| vec_o | output | 16 | Restart vector of winning line |
| vec_ext_o | output | 1 | Winner is the external line |
| status_o | output | 8 | Captured status word |
| status_vld_o | output | 1 | Status beat valid |
| ser_out_o | output | 1 | Serial output latch |

## Verification
The bench sweeps all 256 mask-write words and checks that only the enabled fields land. A design that decoded bit 5, or loaded the masks with bit 3 clear, shows up in the read-back status. It also walks every combination of global enable, mask and request pattern against an arithmetic priority model, which catches a swapped rank or vector. The bench targets these corner cases:
- An edge arriving in the same cycle as a latch clear. A clear-wins design would lose the request.
- A line-7 pin held high across reset or after a clear. A level-sensitive latch would fire again.
- An acknowledge with no request pending. A design that did not qualify the acknowledge would drop the enable.
- Enable and disable in the same cycle.

// File: rtl/intm_pkg.sv
package intm_pkg;
  localparam int unsigned WORD_W  = 8;
  localparam int unsigned NUM_RST = 3;
  localparam int unsigned NUM_SRC = NUM_RST + 1;

  // mask-write word field positions
  localparam int unsigned MW_MASK_EN  = 3;
  localparam int unsigned MW_CLR7     = 4;
  localparam int unsigned MW_SER_EN   = 6;
  localparam int unsigned MW_SER_DATA = 7;

  typedef enum logic [1:0] {
    SRC_EXT = 2'd0,
    SRC_L5  = 2'd1,
    SRC_L6  = 2'd2,
    SRC_L7  = 2'd3
  } src_e;

  typedef struct packed {
    logic               ser_in;
    logic               pend7;
    logic               lvl6;
    logic               lvl5;
    logic               gie;
    logic [NUM_RST-1:0] mask;
  } status_t;
endpackage

// File: rtl/intm_gate_ff.sv
module intm_gate_ff (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  // clear dominates set
  always_ff @(posedge clk) begin
    if (!rst_n)     q_o <= 1'b0;
    else if (clr_i) q_o <= 1'b0;
    else if (set_i) q_o <= 1'b1;
  end
endmodule

// File: rtl/intm_edge_pend.sv
module intm_edge_pend (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  input  logic clr_i,
  output logic pend_o
);
  logic prev_q;
  logic rise;

  assign rise = pin_i & ~prev_q;

  // prev resets high so a pin already high at reset release is not an edge
  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= 1'b1;
    else        prev_q <= pin_i;
  end

  // a fresh edge wins over a clear in the same cycle
  always_ff @(posedge clk) begin
    if (!rst_n)     pend_o <= 1'b0;
    else if (rise)  pend_o <= 1'b1;
    else if (clr_i) pend_o <= 1'b0;
  end
endmodule

// File: rtl/intm_mask_reg.sv
module intm_mask_reg
  import intm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic [WORD_W-1:0] data_i,
  output logic [NUM_RST-1:0] mask_o,
  output logic              ser_o,
  output logic              clr7_o
);
  logic load_mask;
  logic load_ser;

  assign load_mask = wr_i & data_i[MW_MASK_EN];
  assign load_ser  = wr_i & data_i[MW_SER_EN];
  assign clr7_o    = wr_i & data_i[MW_CLR7];

  for (genvar b = 0; b < NUM_RST; b++) begin : g_mask
    logic m_q;
    always_ff @(posedge clk) begin
      if (!rst_n)         m_q <= 1'b1;
      else if (load_mask) m_q <= data_i[b];
    end
    assign mask_o[b] = m_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        ser_o <= 1'b0;
    else if (load_ser) ser_o <= data_i[MW_SER_DATA];
  end
endmodule

// File: rtl/intm_prio.sv
module intm_prio
  import intm_pkg::*;
#(
  parameter int unsigned VEC_W = 16,
  parameter logic [VEC_W-1:0] VEC_L5 = 16'h002C,
  parameter logic [VEC_W-1:0] VEC_L6 = 16'h0034,
  parameter logic [VEC_W-1:0] VEC_L7 = 16'h003C
) (
  input  logic               gie_i,
  input  logic [NUM_RST-1:0] mask_i,
  input  logic               ext_i,
  input  logic               lvl5_i,
  input  logic               lvl6_i,
  input  logic               pend7_i,
  output logic               req_o,
  output src_e               src_o,
  output logic [VEC_W-1:0]   vec_o,
  output logic               vec_ext_o
);
  logic [NUM_SRC-1:0] raw;
  logic [NUM_SRC-1:0] allow;
  logic [NUM_SRC-1:0] live;

  assign raw   = {pend7_i, lvl6_i, lvl5_i, ext_i};
  assign allow = {~mask_i, 1'b1};
  assign live  = raw & allow & {NUM_SRC{gie_i}};
  assign req_o = |live;

  // upward scan: the highest live index is the winner
  always_comb begin
    src_o = SRC_EXT;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (live[i]) src_o = src_e'(i[1:0]);
    end
  end

  always_comb begin
    vec_ext_o = 1'b0;
    unique case (src_o)
      SRC_L7:  vec_o = VEC_L7;
      SRC_L6:  vec_o = VEC_L6;
      SRC_L5:  vec_o = VEC_L5;
      default: begin
        vec_o     = '0;
        vec_ext_o = req_o;
      end
    endcase
  end
endmodule

// File: rtl/intmask_ctrl.sv
module intmask_ctrl
  import intm_pkg::*;
#(
  parameter int unsigned VEC_W = 16,
  parameter logic [VEC_W-1:0] VEC_L5 = 16'h002C,
  parameter logic [VEC_W-1:0] VEC_L6 = 16'h0034,
  parameter logic [VEC_W-1:0] VEC_L7 = 16'h003C
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              irq_ext_i,
  input  logic              irq_l5_i,
  input  logic              irq_l6_i,
  input  logic              irq_l7_i,
  input  logic              en_stb_i,
  input  logic              dis_stb_i,
  input  logic              mw_stb_i,
  input  logic [7:0]        mw_data_i,
  input  logic              rd_stb_i,
  input  logic              ack_i,
  input  logic              ser_in_i,
  output logic              req_o,
  output logic [VEC_W-1:0]  vec_o,
  output logic              vec_ext_o,
  output logic [7:0]        status_o,
  output logic              status_vld_o,
  output logic              ser_out_o
);
  logic               ie_q;
  logic               pend7_q;
  logic [NUM_RST-1:0] mask_q;
  logic               mw_clr7;
  logic               accept;
  src_e               win_src;
  status_t            snap;

  assign accept = ack_i & req_o;

  intm_gate_ff u_gie (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (en_stb_i),
    .clr_i (dis_stb_i | accept),
    .q_o   (ie_q)
  );

  intm_mask_reg u_mask (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_i   (mw_stb_i),
    .data_i (mw_data_i),
    .mask_o (mask_q),
    .ser_o  (ser_out_o),
    .clr7_o (mw_clr7)
  );

  intm_edge_pend u_l7 (
    .clk    (clk),
    .rst_n  (rst_n),
    .pin_i  (irq_l7_i),
    .clr_i  (mw_clr7 | (accept & (win_src == SRC_L7))),
    .pend_o (pend7_q)
  );

  intm_prio #(
    .VEC_W  (VEC_W),
    .VEC_L5 (VEC_L5),
    .VEC_L6 (VEC_L6),
    .VEC_L7 (VEC_L7)
  ) u_prio (
    .gie_i     (ie_q),
    .mask_i    (mask_q),
    .ext_i     (irq_ext_i),
    .lvl5_i    (irq_l5_i),
    .lvl6_i    (irq_l6_i),
    .pend7_i   (pend7_q),
    .req_o     (req_o),
    .src_o     (win_src),
    .vec_o     (vec_o),
    .vec_ext_o (vec_ext_o)
  );

  always_comb begin
    snap.ser_in = ser_in_i;
    snap.pend7  = pend7_q;
    snap.lvl6   = irq_l6_i;
    snap.lvl5   = irq_l5_i;
    snap.gie    = ie_q;
    snap.mask   = mask_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status_o     <= '0;
      status_vld_o <= 1'b0;
    end else begin
      status_vld_o <= rd_stb_i;
      if (rd_stb_i) status_o <= snap;
    end
  end
endmodule

// File: rtl/intm_chk.sv
module intm_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        en_stb,
  input logic        dis_stb,
  input logic        ack,
  input logic        req,
  input logic        vec_ext,
  input logic [15:0] vec,
  input logic        ie,
  input logic        pend7,
  input logic        pin7,
  input logic        mw_stb,
  input logic [7:0]  mw_data,
  input logic [2:0]  mask,
  input logic        ser_out,
  input logic        rd_stb,
  input logic        status_vld
);
  p_enable_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    en_stb && !dis_stb && !(ack && req) |=> ie);
  p_disable_r2: assert property (@(posedge clk) disable iff (!rst_n)
    dis_stb |=> !ie);
  p_accept_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ack && req |=> !ie);
  p_req_needs_enable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    req |-> ie);
  p_edge_latches_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pin7) && $past(rst_n) |=> pend7);
  p_latch_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pend7 && !mw_stb && !ack |=> pend7);
  p_mask_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(mw_stb && mw_data[3]) |=> $stable(mask));
  p_ser_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(mw_stb && mw_data[6]) |=> $stable(ser_out));
  p_status_beat_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb |=> status_vld);
  p_status_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_stb |=> !status_vld);
  p_ext_vector_r10: assert property (@(posedge clk) disable iff (!rst_n)
    vec_ext |-> (req && vec == 16'h0000));
endmodule

bind intmask_ctrl intm_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .en_stb     (en_stb_i),
  .dis_stb    (dis_stb_i),
  .ack        (ack_i),
  .req        (req_o),
  .vec_ext    (vec_ext_o),
  .vec        (vec_o),
  .ie         (ie_q),
  .pend7      (pend7_q),
  .pin7       (irq_l7_i),
  .mw_stb     (mw_stb_i),
  .mw_data    (mw_data_i),
  .mask       (mask_q),
  .ser_out    (ser_out_o),
  .rd_stb     (rd_stb_i),
  .status_vld (status_vld_o)
);

// File: tb/tb_intmask_ctrl.sv
module tb_intmask_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic irq_ext = 0, irq_l5 = 0, irq_l6 = 0, irq_l7 = 0;
  logic en_stb = 0, dis_stb = 0, mw_stb = 0, rd_stb = 0, ack = 0, ser_in = 0;
  logic [7:0]  mw_data = '0;
  logic        req, vec_ext, status_vld, ser_out;
  logic [15:0] vec;
  logic [7:0]  status;

  int n_tests = 0;
  int n_fail  = 0;

  logic [2:0] m_mask;
  logic       m_ie, m_p7, m_so;

  always #10 clk = ~clk;

  intmask_ctrl dut (
    .clk(clk), .rst_n(rst_n),
    .irq_ext_i(irq_ext), .irq_l5_i(irq_l5), .irq_l6_i(irq_l6), .irq_l7_i(irq_l7),
    .en_stb_i(en_stb), .dis_stb_i(dis_stb), .mw_stb_i(mw_stb), .mw_data_i(mw_data),
    .rd_stb_i(rd_stb), .ack_i(ack), .ser_in_i(ser_in),
    .req_o(req), .vec_o(vec), .vec_ext_o(vec_ext),
    .status_o(status), .status_vld_o(status_vld), .ser_out_o(ser_out)
  );

  task automatic chk(input string r, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", r, act, exp);
    end
  endtask

  task automatic mwrite(input logic [7:0] w);
    mw_stb = 1'b1; mw_data = w;
    @(negedge clk);
    mw_stb = 1'b0; mw_data = '0;
  endtask

  task automatic set_en();
    en_stb = 1'b1; @(negedge clk); en_stb = 1'b0;
  endtask

  task automatic set_dis();
    dis_stb = 1'b1; @(negedge clk); dis_stb = 1'b0;
  endtask

  task automatic do_ack();
    ack = 1'b1; @(negedge clk); ack = 1'b0;
  endtask

  task automatic edge7();
    irq_l7 = 1'b1; @(negedge clk); irq_l7 = 1'b0; @(negedge clk);
  endtask

  task automatic do_read(input string r, output logic [7:0] s);
    rd_stb = 1'b1; @(negedge clk); rd_stb = 1'b0;
    chk(r, status_vld, 1);
    s = status;
  endtask

  function automatic logic [7:0] exp_status();
    return {ser_in, m_p7, irq_l6, irq_l5, m_ie, m_mask};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] s;
    // R1 and R5: line 7 held high across reset must not latch
    irq_l7 = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 req", req, 0);
    chk("R1 ser_out", ser_out, 0);
    chk("R1 status_vld", status_vld, 0);
    irq_l7 = 1'b0;
    @(negedge clk);
    m_mask = 3'b111; m_ie = 0; m_p7 = 0; m_so = 0;
    do_read("R1 R5 status", s);
    chk("R1 R5 reset status", s, 8'h07);
    @(negedge clk);
    chk("R8 vld drops", status_vld, 0);

    // R4 R6 R7 R8: sweep all mask-write words
    for (int w = 0; w < 256; w++) begin
      logic [7:0] w8;
      w8 = w[7:0];
      ser_in = w8[0] ^ w8[5];
      if (w8[0]) begin set_en(); m_ie = 1; end
      else begin set_dis(); m_ie = 0; end
      edge7(); m_p7 = 1;
      mwrite(w8);
      if (w8[3]) m_mask = w8[2:0];
      if (w8[6]) m_so = w8[7];
      if (w8[4]) m_p7 = 0;
      chk("R7 ser_out", ser_out, m_so);
      do_read("R8 vld", s);
      chk("R4 R6 R8 status sweep", s, exp_status());
    end

    // R9 R10 R11: enable x mask x request pattern
    for (int ie_v = 0; ie_v < 2; ie_v++) begin
      for (int m = 0; m < 8; m++) begin
        for (int p = 0; p < 16; p++) begin
          logic [3:0] pp;
          logic [2:0] mm;
          logic e7, e6, e5, ee, ex_req;
          int ex_vec;
          int ex_ext;
          pp = p[3:0]; mm = m[2:0];
          mwrite({4'b0001, 1'b1, mm});
          if (ie_v == 1) set_en(); else set_dis();
          if (pp[3]) edge7();
          irq_ext = pp[0]; irq_l5 = pp[1]; irq_l6 = pp[2];
          #1;
          e7 = (ie_v == 1) && !mm[2] && pp[3];
          e6 = (ie_v == 1) && !mm[1] && pp[2];
          e5 = (ie_v == 1) && !mm[0] && pp[1];
          ee = (ie_v == 1) && pp[0];
          ex_req = e7 | e6 | e5 | ee;
          ex_ext = 0;
          if (e7)      ex_vec = 'h3C;
          else if (e6) ex_vec = 'h34;
          else if (e5) ex_vec = 'h2C;
          else begin ex_vec = 0; ex_ext = ee ? 1 : 0; end
          chk("R9 req", req, ex_req);
          chk("R10 vec", vec, ex_vec);
          chk("R10 vec_ext", vec_ext, ex_ext);
          irq_ext = 0; irq_l5 = 0; irq_l6 = 0;
          #1;
          chk("R11 level drop", req, e7);
          @(negedge clk);
        end
      end
    end

    // R3 R6: accept of line 7 clears enable and latch
    mwrite(8'h18); set_en(); edge7(); irq_l6 = 1;
    #1 chk("R10 line7 over line6", vec, 'h3C);
    @(negedge clk);
    do_ack();
    chk("R3 req after accept", req, 0);
    m_mask = 0; m_ie = 0; m_p7 = 0;
    do_read("R8 vld", s);
    chk("R3 R6 accept line7", s, exp_status());

    // R6: accept of line 6 leaves the line-7 latch
    mwrite(8'h0C); edge7(); set_en();
    #1 chk("R10 line6 vec", vec, 'h34);
    @(negedge clk);
    do_ack();
    irq_l6 = 0;
    m_mask = 3'b100; m_ie = 0; m_p7 = 1;
    do_read("R8 vld", s);
    chk("R6 latch kept on line6 accept", s, exp_status());

    // R3: acknowledge with no request has no effect
    mwrite(8'h1F); set_en();
    chk("R3 idle req", req, 0);
    do_ack();
    m_mask = 3'b111; m_ie = 1; m_p7 = 0;
    do_read("R8 vld", s);
    chk("R3 stray ack ignored", s, exp_status());

    // R2: enable and disable together leave enable clear
    en_stb = 1; dis_stb = 1; @(negedge clk); en_stb = 0; dis_stb = 0;
    m_ie = 0;
    do_read("R8 vld", s);
    chk("R2 disable wins", s, exp_status());

    // R6: edge in the same cycle as a clear wins
    irq_l7 = 1; mw_stb = 1; mw_data = 8'h10;
    @(negedge clk);
    mw_stb = 0; mw_data = 0;
    m_p7 = 1;
    do_read("R8 vld", s);
    chk("R6 edge beats clear", s, exp_status());

    // R5: held-high pin does not re-latch after clear
    mwrite(8'h10); m_p7 = 0;
    repeat (3) @(negedge clk);
    do_read("R8 vld", s);
    chk("R5 held high no relatch", s, exp_status());
    irq_l7 = 0;

    // R4: 08h unmasks all
    mwrite(8'h08); m_mask = 0;
    do_read("R8 vld", s);
    chk("R4 08h unmask", s[2:0], 0);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule